// File: doc/BRIEF.md
# MDIO PHY Scan and Duplex Resolver

This block is a management-interface master that finds the Ethernet PHYs attached to a shared MDC/MDIO pair. It decides whether the link runs full or half duplex. A one-cycle `start` pulse launches a pass. The pass probes every PHY address from 1 to 31 in ascending order. It keeps up to four responders and reads the ability word of each one as soon as that PHY is found. It then reads the partner-ability register of the first PHY it found and updates the duplex output.

Each transfer is a read. The master drives a 32-bit preamble of ones and a 16-bit command, then releases the data line while the PHY answers. The data line is split into a driven value, an output enable and a returned value, so the pad ring can build the tri-state buffer. MDC is free-running, and its half period is set in system clocks by `HALF_CYC`. Choose `HALF_CYC` at or above f_clk / 5 MHz so that MDC never exceeds 2.5 MHz. The default of 20 suits a 100 MHz clock.

The results are plain status pins: found-PHY list, count, ability word, no-PHY flag and duplex. They are valid from the `done` pulse and hold until the next pass. No interface carries streaming data, so there is no valid/ready handshake and no back-pressure.

Top module: `mdio_scan_duplex`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next clock and begins a pass. `busy` falls in the same cycle as a one-cycle `done` pulse. A `start` while `busy` is high has no effect, and no MDIO frame is driven after `done` until the next `start`.
- R2: MDC is high for exactly `HALF_CYC` clocks and low for exactly `HALF_CYC` clocks, continuously.
- R3: Every read drives 32 ones, then 16 command bits MSB first: 110110, the 5-bit PHY address, the 5-bit register number. `mdio_oe` is high for these 48 bit times and low for the 20 that follow. `mdio_o` and `mdio_oe` change only in a clock where MDC is low.
- R4: The master samples `mdio_i` in each of the 20 released bit times, in the clock where MDC rises. The register value is samples 3 through 18 (counting from 0), MSB first.
- R5: Addresses 1..31 are read at register 1 in ascending order. An address is present unless it returns 0xFFFF or 0x0000. The scan stops at the fourth present address. `phy_list[5*i +: 5]` holds the i-th found address, unused slots read 0, and `phy_count` is the number found.
- R6: Right after an address is found present, its register 4 is read before the scan moves on. `adv_word` holds the register 4 value of the most recently found PHY.
- R7: When at least one PHY was found, register 5 of the first found PHY is read. With n = reg5 AND `adv_word`, `full_duplex` becomes 1 if n[8] is 1 or n[8:6] = 001, and becomes 0 otherwise.
- R8: If register 5 returns 0xFFFF, or `duplex_lock` is high when that read completes, `full_duplex` keeps its value. `full_duplex` changes only in the `done` cycle.
- R9: With no PHY found, `no_phy` is set at `done`, register 5 is not read and `full_duplex` keeps its value.
- R10: During reset: MDC is 0, `mdio_oe` is 0, `mdio_o` is 1, and `busy`, `done`, `no_phy`, `phy_count` and `full_duplex` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse to launch a scan pass |
| duplex_lock | input | 1 | Freeze the duplex result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO |
| mdio_i | input | 1 | Value read back from the MDIO pad |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| no_phy | output | 1 | Last pass found no PHY |
| phy_count | output | CNT_W | Number of PHYs found |
| phy_list | output | 5*MAX_PHYS | Found addresses, slot i at bits 5i+4:5i |
| adv_word | output | 16 | Register 4 of the last PHY found |
| full_duplex | output | 1 | Resolved duplex |

## Verification
The scan has two stop rules, the count limit and the last address, and both can fire on the same completed read. This is provoked by placing PHYs at addresses 10, 20, 30 and 31. The fourth find then coincides with the final address. The scoreboard of expected transactions must then see exactly one register 4 read at 31, followed directly by the register 5 read of address 10, with no further scan reads. A second `start` pulse is also issued in the middle of a pass, so that it overlaps the running sequencer. It is judged by an unchanged transaction list and a silent line after `done`.

// File: rtl/mdscan_pkg.sv
package mdscan_pkg;
  localparam int PRE_BITS   = 32;
  localparam int CMD_BITS   = 16;
  localparam int RD_BITS    = 20;
  localparam int DRV_BITS   = PRE_BITS + CMD_BITS;
  localparam int FRAME_BITS = DRV_BITS + RD_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  localparam logic [5:0]  CMD_LEAD  = 6'b110110;
  localparam logic [4:0]  REG_ID    = 5'd1;
  localparam logic [4:0]  REG_ABIL  = 5'd4;
  localparam logic [4:0]  REG_PART  = 5'd5;
  localparam logic [15:0] WORD_NONE = 16'hFFFF;
  localparam logic [15:0] WORD_ZERO = 16'h0000;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_st_t;
  typedef enum logic [1:0] {PH_ID, PH_ABIL, PH_PART} rd_phase_t;

  function automatic logic resolve_full(input logic [15:0] part, input logic [15:0] abil);
    logic [15:0] n;
    n = part & abil;
    return n[8] | (n[8:6] == 3'b001);
  endfunction
endpackage

// File: rtl/mdscan_mdc_gen.sv
module mdscan_mdc_gen #(
  parameter int HALF_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic fall_now,
  output logic rise_now
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = (cnt_q == CW'(HALF_CYC - 1));
  // strobes mark the clock edge on which mdc changes level
  assign fall_now = wrap & mdc;
  assign rise_now = wrap & ~mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mdscan_rd_engine.sv
module mdscan_rd_engine
  import mdscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fall_now,
  input  logic        rise_now,
  input  logic        req,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        ack,
  output logic [15:0] rdata
);
  logic                pend_q, act_q;
  logic [4:0]          phy_q, reg_q;
  logic [DRV_BITS-1:0] sh_q;
  logic [BIT_W-1:0]    bit_q;
  logic [15:0]         acc_q;
  logic [DRV_BITS-1:0] frame;
  logic                launch;

  assign frame  = {{PRE_BITS{1'b1}}, CMD_LEAD,
                   (pend_q ? phy_q : phy), (pend_q ? reg_q : regad)};
  assign launch = fall_now & ~act_q & (pend_q | req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      sh_q    <= '0;
      bit_q   <= '0;
      acc_q   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      ack     <= 1'b0;
      rdata   <= '0;
    end else begin
      ack <= 1'b0;
      if (req) begin
        pend_q <= 1'b1;
        phy_q  <= phy;
        reg_q  <= regad;
      end
      if (launch) begin
        pend_q  <= 1'b0;
        act_q   <= 1'b1;
        bit_q   <= '0;
        mdio_oe <= 1'b1;
        mdio_o  <= frame[DRV_BITS-1];
        sh_q    <= {frame[DRV_BITS-2:0], 1'b0};
      end else if (act_q && fall_now) begin
        if (bit_q == BIT_W'(DRV_BITS - 1)) begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          mdio_o <= sh_q[DRV_BITS-1];
          sh_q   <= {sh_q[DRV_BITS-2:0], 1'b0};
        end
        bit_q <= bit_q + BIT_W'(1);
      end
      if (act_q && rise_now && bit_q >= BIT_W'(DRV_BITS)) begin
        acc_q <= {acc_q[14:0], mdio_i};
        if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
          // last sample is the idle bit: the word sits in the previous 16
          act_q <= 1'b0;
          ack   <= 1'b1;
          rdata <= acc_q;
        end
      end
    end
  end
endmodule

// File: rtl/mdscan_seq.sv
module mdscan_seq
  import mdscan_pkg::*;
#(
  parameter int          MAX_PHYS   = 4,
  parameter logic [4:0]  FIRST_ADDR = 5'd1,
  parameter logic [4:0]  LAST_ADDR  = 5'd31,
  localparam int         CNT_W      = $clog2(MAX_PHYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  duplex_lock,
  input  logic                  ack,
  input  logic [15:0]           rdata,
  output logic                  req,
  output logic [4:0]            rd_phy,
  output logic [4:0]            rd_reg,
  output logic                  busy,
  output logic                  done,
  output logic                  no_phy,
  output logic [CNT_W-1:0]      phy_count,
  output logic [5*MAX_PHYS-1:0] phy_list,
  output logic [15:0]           adv_word,
  output logic                  full_duplex
);
  seq_st_t    st_q;
  rd_phase_t  ph_q;
  logic [4:0] addr_q;
  logic       begin_pass, present, slot_wr;

  assign begin_pass = (st_q == ST_IDLE) & start;
  assign present    = (rdata != WORD_NONE) & (rdata != WORD_ZERO);
  assign slot_wr    = (st_q == ST_WAIT) & ack & (ph_q == PH_ID) & present;
  assign req        = (st_q == ST_ISSUE);
  assign rd_phy     = (ph_q == PH_PART) ? phy_list[4:0] : addr_q;

  always_comb begin
    case (ph_q)
      PH_ABIL: rd_reg = REG_ABIL;
      PH_PART: rd_reg = REG_PART;
      default: rd_reg = REG_ID;
    endcase
  end

  for (genvar i = 0; i < MAX_PHYS; i++) begin : g_slot
    logic [4:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q <= '0;
      else if (begin_pass)
        slot_q <= '0;
      else if (slot_wr && phy_count == CNT_W'(i))
        slot_q <= addr_q;
    end
    assign phy_list[5*i +: 5] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ph_q        <= PH_ID;
      addr_q      <= FIRST_ADDR;
      busy        <= 1'b0;
      done        <= 1'b0;
      no_phy      <= 1'b0;
      phy_count   <= '0;
      adv_word    <= '0;
      full_duplex <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            busy      <= 1'b1;
            no_phy    <= 1'b0;
            phy_count <= '0;
            addr_q    <= FIRST_ADDR;
            ph_q      <= PH_ID;
            st_q      <= ST_ISSUE;
          end
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: begin
          if (ack) begin
            case (ph_q)
              PH_ID: begin
                if (present) begin
                  phy_count <= phy_count + CNT_W'(1);
                  ph_q      <= PH_ABIL;
                  st_q      <= ST_ISSUE;
                end else if (addr_q != LAST_ADDR) begin
                  addr_q <= addr_q + 5'd1;
                  st_q   <= ST_ISSUE;
                end else if (phy_count == '0) begin
                  no_phy <= 1'b1;
                  done   <= 1'b1;
                  busy   <= 1'b0;
                  st_q   <= ST_IDLE;
                end else begin
                  ph_q <= PH_PART;
                  st_q <= ST_ISSUE;
                end
              end
              PH_ABIL: begin
                adv_word <= rdata;
                st_q     <= ST_ISSUE;
                if (phy_count == CNT_W'(MAX_PHYS) || addr_q == LAST_ADDR) begin
                  ph_q <= PH_PART;
                end else begin
                  addr_q <= addr_q + 5'd1;
                  ph_q   <= PH_ID;
                end
              end
              default: begin
                if (rdata != WORD_NONE && !duplex_lock)
                  full_duplex <= resolve_full(rdata, adv_word);
                done <= 1'b1;
                busy <= 1'b0;
                st_q <= ST_IDLE;
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_scan_duplex.sv
module mdio_scan_duplex #(
  parameter int  HALF_CYC = 20,
  parameter int  MAX_PHYS = 4,
  localparam int CNT_W    = $clog2(MAX_PHYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  duplex_lock,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  done,
  output logic                  no_phy,
  output logic [CNT_W-1:0]      phy_count,
  output logic [5*MAX_PHYS-1:0] phy_list,
  output logic [15:0]           adv_word,
  output logic                  full_duplex
);
  logic        fall_now, rise_now, req, ack;
  logic [4:0]  rd_phy, rd_reg;
  logic [15:0] rdata;

  mdscan_mdc_gen #(.HALF_CYC(HALF_CYC)) u_mdc (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .fall_now(fall_now), .rise_now(rise_now)
  );

  mdscan_rd_engine u_eng (
    .clk(clk), .rst_n(rst_n), .fall_now(fall_now), .rise_now(rise_now),
    .req(req), .phy(rd_phy), .regad(rd_reg), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .ack(ack), .rdata(rdata)
  );

  mdscan_seq #(.MAX_PHYS(MAX_PHYS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .duplex_lock(duplex_lock),
    .ack(ack), .rdata(rdata), .req(req), .rd_phy(rd_phy), .rd_reg(rd_reg),
    .busy(busy), .done(done), .no_phy(no_phy), .phy_count(phy_count),
    .phy_list(phy_list), .adv_word(adv_word), .full_duplex(full_duplex)
  );
endmodule

// File: rtl/mdscan_checker.sv
module mdscan_checker #(
  parameter int HALF_CYC = 20,
  parameter int MAX_PHYS = 4,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             done,
  input logic             no_phy,
  input logic [CNT_W-1:0] phy_count,
  input logic             full_duplex
);
  logic        mdc_q, seen_q;
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q  <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
    end else begin
      mdc_q <= mdc;
      if (mdc != mdc_q) begin
        run_q  <= 16'd1;
        seen_q <= 1'b1;
      end else if (run_q != 16'hFFFF) begin
        run_q <= run_q + 16'd1;
      end
    end
  end

  // R2: each completed MDC level lasts exactly HALF_CYC clocks
  p_mdc_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && mdc != mdc_q) |-> (run_q == 16'(HALF_CYC)));
  p_mdc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (run_q <= 16'(HALF_CYC)));
  // R3: drive changes only while MDC is low
  p_drive_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);
  // R1: line is driven only inside a pass; done is a single pulse
  p_oe_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: never more than MAX_PHYS recorded
  p_count_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_count <= CNT_W'(MAX_PHYS));
  // R9: the no-PHY flag goes with an empty list
  p_nophy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_phy) |-> (phy_count == '0));
  // R8: duplex moves only in the done cycle
  p_fd_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(full_duplex) |-> done);
endmodule

bind mdio_scan_duplex mdscan_checker #(
  .HALF_CYC(HALF_CYC), .MAX_PHYS(MAX_PHYS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .done(done), .no_phy(no_phy), .phy_count(phy_count),
  .full_duplex(full_duplex)
);

// File: tb/sim_mdio_scan_duplex.sv
module sim_mdio_scan_duplex;
  localparam int HALF = 2;
  localparam int MAXP = 4;
  localparam int CW   = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0, start = 1'b0, duplex_lock = 1'b0;
  logic           mdc, mdio_o, mdio_oe, busy, done, no_phy, full_duplex;
  logic           mdio_i = 1'b1;
  logic [CW-1:0]  phy_count;
  logic [5*MAXP-1:0] phy_list;
  logic [15:0]    adv_word;

  mdio_scan_duplex #(.HALF_CYC(HALF), .MAX_PHYS(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .duplex_lock(duplex_lock),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .busy(busy), .done(done), .no_phy(no_phy), .phy_count(phy_count),
    .phy_list(phy_list), .adv_word(adv_word), .full_duplex(full_duplex)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_r1 [32];
  logic [15:0] m_r4 [32];
  logic [15:0] m_r5 [32];
  logic [9:0]  exp_q [$];
  logic        fd_exp = 1'b0;
  logic [15:0] adv_exp = 16'h0;

  task automatic check_eq(input string rq, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_val(input logic [4:0] a, input logic [4:0] r);
    case (r)
      5'd1:    return m_r1[a];
      5'd4:    return m_r4[a];
      5'd5:    return m_r5[a];
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic clear_model();
    for (int a = 0; a < 32; a++) begin
      m_r1[a] = 16'hFFFF; m_r4[a] = 16'hFFFF; m_r5[a] = 16'hFFFF;
    end
  endtask

  // PHY model and scoreboard monitor
  logic        prev_mdc = 1'b0, armed = 1'b0;
  logic [47:0] hist = '0;
  logic [15:0] word = '0;
  int          rd_idx = 0;
  always @(negedge clk) begin
    if (mdc && !prev_mdc && mdio_oe) hist = {hist[46:0], mdio_o};
    if (!mdc && prev_mdc) begin
      if (mdio_oe) begin
        armed = 1'b1; rd_idx = 0;
      end else if (armed) begin
        if (rd_idx == 0) begin
          check_eq("R3", "preamble", {31'd0, &hist[47:16]}, 32'd1);
          check_eq("R3", "command lead", {26'd0, hist[15:10]}, {26'd0, 6'b110110});
          if (exp_q.size() == 0) begin
            check_eq("R5", "unexpected read", {22'd0, hist[9:0]}, 32'h3FF);
          end else begin
            logic [9:0] e;
            e = exp_q.pop_front();
            check_eq("R5", "read order phy/reg", {22'd0, hist[9:0]}, {22'd0, e});
          end
          word = m_val(hist[9:5], hist[4:0]);
        end
        mdio_i = (rd_idx >= 3 && rd_idx <= 18) ? word[18-rd_idx] : 1'b1;
        rd_idx++;
        if (rd_idx == 20) armed = 1'b0;
      end else begin
        mdio_i = 1'b1;
      end
    end
    prev_mdc = mdc;
  end

  // driver: predicts transactions and results, runs one pass
  task automatic run_scan(input logic lock, input logic poke, input string tag);
    int found = 0;
    logic [4:0] lst [4];
    logic [15:0] v;
    int t = 0;
    for (int i = 0; i < 4; i++) lst[i] = 5'd0;
    for (int a = 1; a <= 31; a++) begin
      exp_q.push_back({5'(a), 5'd1});
      v = m_r1[a];
      if (v != 16'hFFFF && v != 16'h0000) begin
        lst[found] = 5'(a);
        found++;
        exp_q.push_back({5'(a), 5'd4});
        adv_exp = m_r4[a];
        if (found == 4) break;
      end
    end
    if (found > 0) begin
      exp_q.push_back({lst[0], 5'd5});
      v = m_r5[lst[0]];
      if (v != 16'hFFFF && !lock) begin
        logic [15:0] n;
        n = v & adv_exp;
        fd_exp = n[8] | (n[8:6] == 3'b001);
      end
    end
    duplex_lock = lock;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check_eq("R1", {tag, " busy after start"}, {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done && t < 40000) begin
      @(negedge clk);
      t++;
    end
    check_eq("R1", {tag, " done seen"}, {31'd0, done}, 32'd1);
    check_eq("R1", {tag, " busy low at done"}, {31'd0, busy}, 32'd0);
    check_eq("R5", {tag, " phy_count"}, {29'd0, phy_count}, 32'(found));
    for (int i = 0; i < 4; i++)
      check_eq("R5", {tag, " phy slot"}, {27'd0, phy_list[5*i +: 5]}, {27'd0, lst[i]});
    if (found > 0) check_eq("R6", {tag, " adv_word"}, {16'd0, adv_word}, {16'd0, adv_exp});
    check_eq("R9", {tag, " no_phy"}, {31'd0, no_phy}, {31'd0, found == 0});
    check_eq("R7", {tag, " full_duplex"}, {31'd0, full_duplex}, {31'd0, fd_exp});
    check_eq("R5", {tag, " all reads issued"}, 32'(exp_q.size()), 32'd0);
    t = 0;
    repeat (200) begin
      @(negedge clk);
      if (mdio_oe) t++;
    end
    check_eq("R1", {tag, " line idle after done"}, 32'(t), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    logic pm;
    clear_model();
    repeat (3) @(negedge clk);
    check_eq("R10", "mdc in reset", {31'd0, mdc}, 32'd0);
    check_eq("R10", "oe in reset", {31'd0, mdio_oe}, 32'd0);
    check_eq("R10", "mdio_o in reset", {31'd0, mdio_o}, 32'd1);
    check_eq("R10", "busy/done/no_phy in reset", {29'd0, busy, done, no_phy}, 32'd0);
    check_eq("R10", "count/duplex in reset", {28'd0, phy_count, full_duplex}, 32'd0);
    rst_n = 1'b1;

    // R2: one full MDC period in clocks
    pm = mdc;
    forever begin @(negedge clk); if (mdc && !pm) break; pm = mdc; end
    cnt = 0; pm = mdc;
    forever begin @(negedge clk); cnt++; if (mdc && !pm) break; pm = mdc; end
    check_eq("R2", "mdc period", 32'(cnt), 32'(2*HALF));

    // S1: PHYs at 3 and 20, address 17 answers zeros; 001 pattern -> full
    clear_model();
    m_r1[3] = 16'h7809; m_r4[3] = 16'h01E1; m_r5[3] = 16'h45E1;
    m_r1[17] = 16'h0000;
    m_r1[20] = 16'h7849; m_r4[20] = 16'h0061;
    run_scan(1'b0, 1'b1, "S1 R4 R7");

    // S2: five responders, stop at fourth; 011 pattern -> half
    clear_model();
    m_r1[1] = 16'h1111; m_r4[1] = 16'h05E1; m_r5[1] = 16'h00C0;
    m_r1[2] = 16'h2222; m_r4[2] = 16'h0021;
    m_r1[5] = 16'h5555; m_r4[5] = 16'h01A1;
    m_r1[9] = 16'h9999; m_r4[9] = 16'h01E1;
    m_r1[12] = 16'hCCCC; m_r4[12] = 16'h1234;
    run_scan(1'b0, 1'b0, "S2 R5 R7");

    // S3: partner reads all ones -> duplex kept at 0
    clear_model();
    m_r1[3] = 16'h7809; m_r4[3] = 16'h01E1;
    m_r1[20] = 16'h7849; m_r4[20] = 16'h0061;
    run_scan(1'b0, 1'b0, "S3 R8 ones");

    // S4: fourth PHY at the last address, bit 8 -> full
    clear_model();
    m_r1[10] = 16'hA0A0; m_r4[10] = 16'h0001; m_r5[10] = 16'h0100;
    m_r1[20] = 16'hB0B0; m_r4[20] = 16'h0002;
    m_r1[30] = 16'hC0C0; m_r4[30] = 16'h0003;
    m_r1[31] = 16'hD0D0; m_r4[31] = 16'h0100;
    run_scan(1'b0, 1'b0, "S4 R5 R6");

    // S5: lock holds duplex although the result would be half
    clear_model();
    m_r1[1] = 16'h1111; m_r4[1] = 16'h01E1; m_r5[1] = 16'h00C0;
    run_scan(1'b1, 1'b0, "S5 R8 lock");

    // S6: empty bus
    clear_model();
    run_scan(1'b0, 1'b0, "S6 R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule